// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Node with Return-Opcode Snooping

This block is the interrupt front end of one peripheral on a bus whose interrupt priority runs through a chain of enable signals. Devices nearer the start of the chain win. The node holds two flags. The pending flag records that the peripheral wants the CPU. The in-service flag records that the CPU has accepted that request and is running its handler. From these flags and the chain enable arriving from upstream, the node decides three things: whether to pull the shared open-drain request line, whether to pass the enable on to downstream devices, and whether to answer an acknowledge cycle with its vector.

The CPU acknowledges an interrupt with a special bus cycle. The opcode-fetch strobe goes low while the read strobe stays high, and the chain is then given time to settle. After that the I/O-request strobe also goes low, and the one node that is pending and enabled places its 8-bit vector on the data bus. The node also watches ordinary opcode fetches. When it sees the two-byte return-from-interrupt sequence while it is the highest-priority device in service, it ends its own service without any software write.

All strobes are active low and are sampled on the rising edge of `clk`. The data bus is split into an input and a driven output with an output enable. The open-drain request is given as a pull-down enable. Control pins are plain levels; the block has no streaming data path and so no valid/ready handshake.

Top module: `irq_chain_node`

## Requirements
- R1: After reset, pending and in-service are clear, `irq_pull_o` is 0, `data_oe_o` is 0, `ieo_o` equals `iei_i`, and the vector register holds `RESET_VECTOR` (default 8'hE0).
- R2: A high `req_i` outside an acknowledge cycle sets pending at the next clock edge. A high `clr_ip_i` clears pending at the next edge, and it wins over a simultaneous `req_i`.
- R3: While pending is set, `ieo_o` is 0 whatever `iei_i` is. While both flags are clear, `ieo_o` follows `iei_i`.
- R4: `irq_pull_o` is 1 exactly when pending is set, in-service is clear, and `iei_i` is 1.
- R5: An acknowledge cycle is any cycle with `m1_n_i`=0 and `rd_n_i`=1. In such a cycle `req_i` is ignored, and the cycle never clears pending.
- R6: While `m1_n_i`=0, `rd_n_i`=1, `iorq_n_i`=0, pending is set and `iei_i`=1, `data_oe_o` is 1 and `data_o` carries the vector in the same cycle, and in-service sets at the next edge. If `iei_i`=0 the node neither drives nor sets in-service. Otherwise `data_oe_o` is 0 and `data_o` is 0.
- R7: While in-service is set, `ieo_o` is 0 and `irq_pull_o` is 0.
- R8: A fetch is a cycle with `m1_n_i`=0 and `rd_n_i`=0. Its opcode is `data_i` in its first cycle. Fetches of 8'hED and then 8'h4D, with no other fetch between them and `iei_i`=1 during the first cycle of the second fetch, clear in-service at the next edge. Any other byte between them breaks the sequence, and `iei_i`=0 at the second byte prevents the clear.
- R9: A high `clr_ius_i` clears in-service at the next edge.
- R10: A high `vec_wr_i` loads `vec_wdata_i` into the vector register at the next edge, and later acknowledges drive the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Service request from the peripheral function |
| clr_ip_i | input | 1 | Clear-pending strobe |
| clr_ius_i | input | 1 | Clear-in-service strobe |
| m1_n_i | input | 1 | Opcode-fetch strobe, active low |
| iorq_n_i | input | 1 | I/O-request strobe, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| data_i | input | DATA_W | Data bus as seen by the node |
| iei_i | input | 1 | Chain enable from higher priority |
| vec_wr_i | input | 1 | Vector register write strobe |
| vec_wdata_i | input | DATA_W | Vector register write data |
| irq_pull_o | output | 1 | Pull the shared request line low |
| ieo_o | output | 1 | Chain enable to lower priority |
| data_o | output | DATA_W | Vector driven onto the bus |
| data_oe_o | output | 1 | Data bus output enable |

## Verification
The hardest state to reach from the ports is the end of service by snooping. To get there, the node must first hold pending, win a full acknowledge with the chain enabled, and then see exactly the two-fetch return sequence. The two near misses must also be covered: a foreign fetch between the two bytes, and the chain enable dropping at the second byte. The stimulus reaches each of these with a sequence of whole bus-cycle tasks, which fetch and acknowledge over several clocks. A behavioural model, updated on every clock, predicts each output so that every intermediate cycle of those sequences is compared.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned OPC_W = 8;
  localparam logic [OPC_W-1:0] RET_PREFIX = 8'hED;
  localparam logic [OPC_W-1:0] RET_OPCODE = 8'h4D;

  typedef struct packed {
    logic fetch;        // opcode fetch in progress
    logic fetch_start;  // first cycle of a fetch
    logic ack;          // acknowledge window (settle or drive)
    logic ack_io;       // acknowledge with IO request: vector phase
  } bus_phase_t;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       m1_n,
  input  logic       iorq_n,
  input  logic       rd_n,
  output bus_phase_t phase
);
  logic fetch_d;
  logic fetch_now;

  assign fetch_now = ~m1_n & ~rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) fetch_d <= 1'b0;
    else        fetch_d <= fetch_now;
  end

  always_comb begin
    phase.fetch       = fetch_now;
    phase.fetch_start = fetch_now & ~fetch_d;
    phase.ack         = ~m1_n & rd_n;
    phase.ack_io      = ~m1_n & rd_n & ~iorq_n;
  end
endmodule

// File: rtl/irq_ret_snoop.sv
module irq_ret_snoop
  import irq_chain_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_phase_t        phase,
  input  logic [DATA_W-1:0] data,
  input  logic              iei,
  output logic              ret_hit
);
  logic prefix_seen;
  logic is_prefix;
  logic is_opcode;

  assign is_prefix = (data[OPC_W-1:0] == RET_PREFIX);
  assign is_opcode = (data[OPC_W-1:0] == RET_OPCODE);

  // A fetch start either arms (prefix) or disarms (anything else) the tracker.
  always_ff @(posedge clk) begin
    if (!rst_n)                 prefix_seen <= 1'b0;
    else if (phase.fetch_start) prefix_seen <= is_prefix;
  end

  assign ret_hit = phase.fetch_start & prefix_seen & is_opcode & iei;
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_phase_t phase,
  input  logic       iei,
  input  logic       req,
  input  logic       clr_ip,
  input  logic       clr_ius,
  input  logic       ret_hit,
  output logic       pend,
  output logic       serv,
  output logic       grant
);
  logic pend_q;
  logic serv_q;

  assign grant = phase.ack_io & pend_q & iei;

  always_ff @(posedge clk) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (clr_ip)              pend_q <= 1'b0;
    else if (req && !phase.ack)   pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   serv_q <= 1'b0;
    else if (clr_ius || ret_hit)  serv_q <= 1'b0;
    else if (grant)               serv_q <= 1'b1;
  end

  assign pend = pend_q;
  assign serv = serv_q;
endmodule

// File: rtl/irq_vector_reg.sv
module irq_vector_reg #(
  parameter int unsigned       DATA_W       = 8,
  parameter logic [DATA_W-1:0] RESET_VECTOR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              drive,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  logic [DATA_W-1:0] vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  vec_q <= RESET_VECTOR;
    else if (wr) vec_q <= wdata;
  end

  assign bus_out = drive ? vec_q : '0;
  assign bus_oe  = drive;
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
  import irq_chain_pkg::*;
#(
  parameter int unsigned       DATA_W       = 8,
  parameter logic [DATA_W-1:0] RESET_VECTOR = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              clr_ip_i,
  input  logic              clr_ius_i,
  input  logic              m1_n_i,
  input  logic              iorq_n_i,
  input  logic              rd_n_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              iei_i,
  input  logic              vec_wr_i,
  input  logic [DATA_W-1:0] vec_wdata_i,
  output logic              irq_pull_o,
  output logic              ieo_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  bus_phase_t phase;
  logic ret_hit;
  logic pend;
  logic serv;
  logic grant;

  irq_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .m1_n(m1_n_i), .iorq_n(iorq_n_i), .rd_n(rd_n_i),
    .phase(phase)
  );

  irq_ret_snoop #(.DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .data(data_i), .iei(iei_i), .ret_hit(ret_hit)
  );

  irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .phase(phase), .iei(iei_i),
    .req(req_i), .clr_ip(clr_ip_i), .clr_ius(clr_ius_i),
    .ret_hit(ret_hit), .pend(pend), .serv(serv), .grant(grant)
  );

  irq_vector_reg #(.DATA_W(DATA_W), .RESET_VECTOR(RESET_VECTOR)) u_vec (
    .clk(clk), .rst_n(rst_n), .wr(vec_wr_i), .wdata(vec_wdata_i),
    .drive(grant), .bus_out(data_o), .bus_oe(data_oe_o)
  );

  // Either flag blocks the downstream chain; request only when this node leads.
  assign ieo_o      = iei_i & ~pend & ~serv;
  assign irq_pull_o = iei_i & pend & ~serv;
endmodule

// File: rtl/irq_chain_node_chk.sv
module irq_chain_node_chk (
  input logic clk,
  input logic rst_n,
  input logic m1_n,
  input logic iorq_n,
  input logic rd_n,
  input logic iei,
  input logic req,
  input logic clr_ip,
  input logic clr_ius,
  input logic pend,
  input logic serv,
  input logic ieo,
  input logic irq_pull,
  input logic oe
);
  AST_PEND_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) pend |-> !ieo); // R3
  AST_SERV_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) serv |-> (!ieo && !irq_pull)); // R7
  AST_CLEAR_BEATS_REQ: assert property (@(posedge clk) disable iff (!rst_n) clr_ip |=> !pend); // R2
  AST_REQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n) (req && !clr_ip && !(!m1_n && rd_n)) |=> pend); // R2
  AST_ACK_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n) (!m1_n && rd_n && pend && !clr_ip) |=> pend); // R5
  AST_ACK_NO_NEW_REQ: assert property (@(posedge clk) disable iff (!rst_n) (!m1_n && rd_n && !pend) |=> !pend); // R5
  AST_NO_VEC_WITHOUT_IEI: assert property (@(posedge clk) disable iff (!rst_n) !iei |-> !oe); // R6
  AST_VEC_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n) oe |-> (!m1_n && !iorq_n && rd_n)); // R6
  AST_GRANT_SETS_SERV: assert property (@(posedge clk) disable iff (!rst_n) (oe && !clr_ius) |=> serv); // R6
  AST_IRQ_NEEDS_LEAD: assert property (@(posedge clk) disable iff (!rst_n) irq_pull |-> (iei && pend)); // R4
  AST_CLR_SERV: assert property (@(posedge clk) disable iff (!rst_n) clr_ius |=> !serv); // R9
endmodule

bind irq_chain_node irq_chain_node_chk u_chk (
  .clk(clk), .rst_n(rst_n), .m1_n(m1_n_i), .iorq_n(iorq_n_i), .rd_n(rd_n_i),
  .iei(iei_i), .req(req_i), .clr_ip(clr_ip_i), .clr_ius(clr_ius_i),
  .pend(pend), .serv(serv), .ieo(ieo_o), .irq_pull(irq_pull_o), .oe(data_oe_o)
);

// File: tb/irq_chain_node_tb_top.sv
module irq_chain_node_tb_top;
  localparam int unsigned W = 8;
  localparam logic [W-1:0] RVEC = 8'hE0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, clr_ip = 0, clr_ius = 0;
  logic m1_n = 1, iorq_n = 1, rd_n = 1;
  logic [W-1:0] dbus = '0;
  logic iei = 1;
  logic vwr = 0;
  logic [W-1:0] vwdata = '0;
  logic irq_pull, ieo, oe;
  logic [W-1:0] dout;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase_tag = "R1";

  // model state
  bit m_ip, m_ius, m_saw, m_fprev;
  int m_vec;

  always #10 clk = ~clk;

  irq_chain_node #(.DATA_W(W), .RESET_VECTOR(RVEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .clr_ip_i(clr_ip), .clr_ius_i(clr_ius),
    .m1_n_i(m1_n), .iorq_n_i(iorq_n), .rd_n_i(rd_n), .data_i(dbus), .iei_i(iei),
    .vec_wr_i(vwr), .vec_wdata_i(vwdata), .irq_pull_o(irq_pull), .ieo_o(ieo),
    .data_o(dout), .data_oe_o(oe)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic void finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endfunction

  // Reference model: advance on the edge just taken, then compare outputs.
  always @(negedge clk) begin
    bit fetch, fstart, ack, ackio, hit, drive;
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
    end
    if (!rst_n) begin
      m_ip = 0; m_ius = 0; m_saw = 0; m_fprev = 0; m_vec = RVEC;
    end else begin
      fetch  = !m1_n && !rd_n;
      ack    = !m1_n && rd_n;
      ackio  = ack && !iorq_n;
      fstart = fetch && !m_fprev;
      hit    = fstart && m_saw && dbus == 8'h4D && iei;
      drive  = ackio && m_ip && iei;
      if (fstart) m_saw = (dbus == 8'hED);
      m_fprev = fetch;
      if (clr_ius || hit) m_ius = 0; else if (drive) m_ius = 1;
      if (clr_ip) m_ip = 0; else if (req && !ack) m_ip = 1;
      if (vwr) m_vec = vwdata;
      #1;
      begin
        bit eoe;
        eoe = !m1_n && rd_n && !iorq_n && m_ip && iei;
        check({phase_tag, " R4 irq"}, irq_pull, iei && m_ip && !m_ius);
        check({phase_tag, " R3/R7 ieo"}, ieo, iei && !m_ip && !m_ius);
        check({phase_tag, " R6 oe"}, oe, eoe);
        check({phase_tag, " R10 vec"}, dout, eoe ? m_vec : 0);
      end
    end
  end

  // Inputs change 3 time units after the falling edge.
  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #3; end
  endtask

  task automatic bus_idle();
    m1_n = 1; iorq_n = 1; rd_n = 1; dbus = '0;
  endtask

  task automatic fetch_op(logic [7:0] op);
    m1_n = 0; rd_n = 0; dbus = op; tick();
    dbus = 8'h00; tick();
    bus_idle(); tick();
  endtask

  task automatic ack_cycle();
    m1_n = 0; rd_n = 1; tick(2);
    iorq_n = 0; #2;
    check({phase_tag, " direct oe"}, oe, m_ip && iei);
    tick(2);
    bus_idle(); tick();
  endtask

  initial begin
    tick(3);
    rst_n = 1; #2;
    phase_tag = "R1";
    check("R1 reset ieo", ieo, 1);
    check("R1 reset irq", irq_pull, 0);
    check("R1 reset oe", oe, 0);
    tick();

    phase_tag = "R2";
    req = 1; tick(); req = 0; #2;
    check("R2 pending after req", irq_pull, 1);
    clr_ip = 1; req = 1; tick(); clr_ip = 0; req = 0; #2;
    check("R2 clear wins", irq_pull, 0);
    tick();

    phase_tag = "R3";
    req = 1; tick(); req = 0; iei = 0; #2;
    check("R3 pending blocks chain", ieo, 0);
    check("R4 no irq without iei", irq_pull, 0);
    iei = 1; clr_ip = 1; tick(); clr_ip = 0; tick();

    phase_tag = "R5";
    m1_n = 0; rd_n = 1; req = 1; tick(); req = 0; tick();
    bus_idle(); #2;
    check("R5 req ignored in ack", irq_pull, 0);
    tick();
    req = 1; tick(); req = 0;
    m1_n = 0; rd_n = 1; tick(2); bus_idle(); #2;
    check("R5 ack keeps pending", irq_pull, 1);
    tick();

    phase_tag = "R6";
    iei = 0; ack_cycle(); iei = 1; #2;
    check("R6 no service when iei low", irq_pull, 1);
    ack_cycle(); #2;
    check("R7 serv blocks irq", irq_pull, 0);
    check("R7 serv blocks chain", ieo, 0);

    phase_tag = "R8";
    clr_ip = 1; tick(); clr_ip = 0;
    fetch_op(8'hED); fetch_op(8'h00); fetch_op(8'h4D); #2;
    check("R8 broken sequence keeps serv", ieo, 0);
    fetch_op(8'hED); iei = 0; fetch_op(8'h4D); iei = 1; #2;
    check("R8 iei low keeps serv", ieo, 0);
    fetch_op(8'hED); fetch_op(8'h4D); #2;
    check("R8 return clears serv", ieo, 1);

    phase_tag = "R9";
    req = 1; tick(); req = 0; ack_cycle();
    clr_ip = 1; tick(); clr_ip = 0; #2;
    check("R9 still in service", ieo, 0);
    clr_ius = 1; tick(); clr_ius = 0; #2;
    check("R9 clear in service", ieo, 1);

    phase_tag = "R10";
    vwr = 1; vwdata = 8'h5A; tick(); vwr = 0;
    req = 1; tick(); req = 0;
    m1_n = 0; rd_n = 1; tick(); iorq_n = 0; #2;
    check("R10 new vector driven", dout, 8'h5A);
    tick(); bus_idle(); tick();
    clr_ius = 1; clr_ip = 1; tick(); clr_ius = 0; clr_ip = 0; tick(2);

    finish_run();
  end
endmodule